// File: doc/BRIEF.md
# Port access strobe generator

An 8-bit general-purpose output/input port that tells an external peripheral when the processor has touched it. A processor write loads the port output register. After a fixed delay, an active-low write strobe pulses for two clock cycles. A processor read returns the synchronized pin value latched in the read cycle. After a longer fixed delay, an active-low read strobe pulses for two cycles. That read strobe samples nothing. It only tells the peripheral that it may now present the next byte.

One control bit gates strobe generation. Each strobe path is a short shift-register delay line. Accesses on adjacent cycles therefore merge into one continuous low level. Read and write strobes run independently and may overlap. All timing is counted in the port clock.

Top module: `port_strobe_gen`

## Requirements
- R1: While the strobe enable is low, neither strobe asserts. Dropping the enable in the middle of a sequence returns both strobes high after the next edge and discards any pending pulse, so no strobe follows when the enable comes back.
- R2: An isolated access produces a strobe that stays low for exactly two consecutive cycles.
- R3: A write sampled at edge k loads `port_o` with `wr_data_i` after edge k. `wr_stb_no` is low after edges k+2 and k+3 and high again after edge k+4.
- R4: A read sampled at edge k drives `rd_stb_no` low after edges k+3 and k+4 and high again after edge k+5.
- R5: A read at edge k captures the pin value through a two-stage synchronizer. A value placed on `pin_i` at least two edges before edge k appears on `rd_data_o` after edge k, whatever the enable.
- R6: `rd_data_o` changes only at a read. Pin changes after the read, including during and after the read strobe, leave it unchanged.
- R7: Accesses of the same kind on adjacent cycles keep the strobe low without a gap, from the first access's start until the last access's end.
- R8: Read and write strobes are tracked independently. Any mix of read and write accesses gives each strobe exactly the level that its own accesses alone would give.
- R9: During reset `port_o` and `rd_data_o` are 0 and both strobes are high (1).
- R10: A strobe never falls unless an access of its own kind occurred at the matching delay with the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stb_en_i | input | 1 | Control bit enabling strobe generation |
| wr_en_i | input | 1 | Processor write to the port this cycle |
| wr_data_i | input | PORT_W | Byte written to the port |
| rd_en_i | input | 1 | Processor read of the port this cycle |
| rd_data_o | output | PORT_W | Pin value captured at the last read |
| port_o | output | PORT_W | Port output register |
| pin_i | input | PORT_W | Port pins from the peripheral |
| rd_stb_no | output | 1 | Active-low read strobe |
| wr_stb_no | output | 1 | Active-low write strobe |

## Verification
The strobe paths are swept over every 8-cycle write pattern, each paired with a derived read pattern, with the enable both high and low. These runs separate a correct delay and width from an off-by-one delay line. They show whether back-to-back accesses merge or leave a gap, and whether one path leaks into the other. The read path is swept over all 256 pin values, and the pins are changed right after each read, which shows whether the capture happens at the read or later at the strobe. A directed mid-sequence enable drop shows whether pending pulses are flushed or merely masked.

// File: rtl/port_stb_pkg.sv
package port_stb_pkg;
  localparam int unsigned PORT_W_DEF  = 8;
  localparam int unsigned WR_DLY_DEF  = 2;  // edges from write to strobe low
  localparam int unsigned RD_DLY_DEF  = 3;  // edges from read to strobe low
  localparam int unsigned STB_LEN_DEF = 2;  // strobe low cycles
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/strobe_delay.sv
module strobe_delay #(
  parameter int unsigned DLY = 2,
  parameter int unsigned LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic acc_i,
  output logic stb_no
);
  localparam int unsigned DEPTH = DLY + LEN - 1;
  localparam int unsigned WIN_LO = DLY - 1;

  logic [DEPTH-1:0] line_q;
  logic             stb_nq;

  // bit j set after edge k+j; registered strobe covers taps DLY-1..DEPTH-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      stb_nq <= 1'b1;
    end else if (!en_i) begin
      line_q <= '0;
      stb_nq <= 1'b1;
    end else begin
      line_q <= {line_q[DEPTH-2:0], acc_i};
      stb_nq <= ~|line_q[DEPTH-1:WIN_LO];
    end
  end

  assign stb_no = stb_nq;

  p_min_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stb_no) && en_i) |=> !stb_no);
endmodule

// File: rtl/port_strobe_gen.sv
module port_strobe_gen
  import port_stb_pkg::*;
#(
  parameter int unsigned PORT_W  = PORT_W_DEF,
  parameter int unsigned WR_DLY  = WR_DLY_DEF,
  parameter int unsigned RD_DLY  = RD_DLY_DEF,
  parameter int unsigned STB_LEN = STB_LEN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_en_i,
  input  logic              wr_en_i,
  input  logic [PORT_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [PORT_W-1:0] rd_data_o,
  output logic [PORT_W-1:0] port_o,
  input  logic [PORT_W-1:0] pin_i,
  output logic              rd_stb_no,
  output logic              wr_stb_no
);
  logic [PORT_W-1:0] port_q, rd_q, pin_sync_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_en_i) port_q <= wr_data_i;
      if (rd_en_i) rd_q   <= pin_sync_w;
    end
  end

  assign port_o    = port_q;
  assign rd_data_o = rd_q;

  pin_sync #(.W(PORT_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .sync_o(pin_sync_w)
  );

  strobe_delay #(.DLY(WR_DLY), .LEN(STB_LEN)) u_wr_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (stb_en_i),
    .acc_i (wr_en_i),
    .stb_no(wr_stb_no)
  );

  strobe_delay #(.DLY(RD_DLY), .LEN(STB_LEN)) u_rd_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (stb_en_i),
    .acc_i (rd_en_i),
    .stb_no(rd_stb_no)
  );

  p_stb_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stb_en_i) |-> (rd_stb_no && wr_stb_no));

  p_port_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> (port_o == $past(wr_data_i)));

  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rd_data_o));

  // fixed-depth timing checks for the default delay configuration
  if (WR_DLY == 2 && RD_DLY == 3 && STB_LEN == 2) begin : g_dflt_chk
    p_wr_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(wr_en_i, 3) && $past(stb_en_i, 3) && $past(stb_en_i, 2) && $past(stb_en_i))
      |-> !wr_stb_no);
    p_rd_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rd_en_i, 4) && $past(stb_en_i, 4) && $past(stb_en_i, 3) &&
       $past(stb_en_i, 2) && $past(stb_en_i)) |-> !rd_stb_no);
    p_wr_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wr_stb_no) |-> $past(wr_en_i, 3));
    p_rd_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rd_stb_no) |-> $past(rd_en_i, 4));
  end
endmodule

// File: tb/port_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module port_strobe_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       stb_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, pin = '0;
  logic [7:0] rd_data, port;
  logic       rd_stb_n, wr_stb_n;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  port_strobe_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .stb_en_i(stb_en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .port_o(port), .pin_i(pin),
    .rd_stb_no(rd_stb_n), .wr_stb_no(wr_stb_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one sweep run: write pattern p, read pattern q over 8 access cycles
  task automatic run_pat(input bit en, input logic [7:0] p, input logic [7:0] q,
                         inout logic [7:0] exp_port);
    bit wa[0:15];
    bit ra[0:15];
    for (int i = 0; i < 16; i++) begin
      wa[i] = (i < 8) ? p[i] : 1'b0;
      ra[i] = (i < 8) ? q[i] : 1'b0;
    end
    stb_en = en;
    for (int t = 0; t < 14; t++) begin
      if (t > 0) begin
        int e = t - 1;
        bit wl = en && ((e >= 2 && wa[e-2]) || (e >= 3 && wa[e-3]));
        bit rl = en && ((e >= 3 && ra[e-3]) || (e >= 4 && ra[e-4]));
        if (en) begin
          chk("R2 R3 R7 R8 R10 wr_stb", {31'd0, wr_stb_n}, {31'd0, !wl});
          chk("R2 R4 R7 R8 R10 rd_stb", {31'd0, rd_stb_n}, {31'd0, !rl});
        end else begin
          chk("R1 wr_stb off", {31'd0, wr_stb_n}, 32'd1);
          chk("R1 rd_stb off", {31'd0, rd_stb_n}, 32'd1);
        end
        chk("R3 port_o", {24'd0, port}, {24'd0, exp_port});
      end
      wr_en = wa[t];
      rd_en = ra[t];
      wr_data = p ^ 8'(t * 29);
      if (wa[t]) exp_port = wr_data;
      tick();
    end
  endtask

  initial begin
    logic [7:0] exp_port = '0;
    wr_en = 0; rd_en = 0;
    repeat (2) @(negedge clk);
    chk("R9 port_o reset", {24'd0, port}, 32'd0);
    chk("R9 rd_data reset", {24'd0, rd_data}, 32'd0);
    chk("R9 wr_stb reset", {31'd0, wr_stb_n}, 32'd1);
    chk("R9 rd_stb reset", {31'd0, rd_stb_n}, 32'd1);
    rst_ni = 1'b1;
    tick();

    for (int en = 0; en < 2; en++)
      for (int p = 0; p < 256; p++)
        run_pat(en[0], 8'(p), 8'((p * 37 + 11) & 255), exp_port);

    // mid-sequence enable drop: R1
    stb_en = 1; wr_en = 1; wr_data = 8'h5A;
    tick();                                   // edge a
    wr_en = 0;
    tick(); tick();                           // a+1, a+2
    chk("R3 wr_stb low after a+2", {31'd0, wr_stb_n}, 32'd0);
    stb_en = 0;
    tick();                                   // a+3
    chk("R1 wr_stb high after drop", {31'd0, wr_stb_n}, 32'd1);
    stb_en = 1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R1 flushed no strobe", {31'd0, wr_stb_n}, 32'd1);
    end

    // read capture over all pin values, enable alternating: R5 R6
    for (int v = 0; v < 256; v++) begin
      stb_en = v[0];
      pin = 8'(v);
      tick(); tick();
      rd_en = 1;
      tick();
      rd_en = 0;
      chk("R5 rd_data capture", {24'd0, rd_data}, v);
      pin = ~8'(v);
      tick(); tick(); tick(); tick();
      chk("R6 rd_data held past strobe", {24'd0, rd_data}, v);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule